// File: doc/BRIEF.md
# Split-operand unsigned multiplier

This block multiplies two unsigned operands of 2n bits each into a 4n-bit product by using four n-by-n multipliers, one per pairing of operand halves. Each operand is cut into an upper and a lower half. The four half-by-half products are then placed at their binary weights and summed.

The summation is kept shallow. The lowest n bits of the low-by-low product are already final, so they go straight to the output. Every other term falls inside a 3n-bit window above them. In that window, two rows of carry-save adders reduce four operands to two, and one 3n-bit carry-propagate adder finishes the sum. Because the full product always fits in 4n bits, no carry ever leaves the window.

A parameter places an output register after the adder. When the register is on, the product appears one clock after the operands and is cleared by reset. When it is off, the block is purely combinational.

Top module: `composite_mult`

## Requirements
- R1: `product_o` equals the unsigned product of `a_i` and `b_i`, at 4n bits, for any operand values.
- R2: With `OUT_REG` = 1, `product_o` shows the product of the operands sampled at the previous rising clock edge. A change on the inputs between edges does not alter `product_o`.
- R3: With `OUT_REG` = 1, `product_o` is zero while `rst_ni` is low, whatever the operands are.
- R4: Bits n-1..0 of `product_o` equal the low n bits of `a_i[n-1:0] * b_i[n-1:0]` and do not depend on the upper operand halves.
- R5: When both operands are all ones, the product is 2^(4n) - 2^(2n+1) + 1, with no bit lost.
- R6: If either operand is zero, `product_o` is zero.
- R7: Carries that arise in the middle 2n columns propagate correctly into the top n bits of the product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset of the output register |
| a_i | input | 2*HALF_W | First unsigned operand |
| b_i | input | 2*HALF_W | Second unsigned operand |
| product_o | output | 4*HALF_W | Unsigned product |

## Verification
The bench drives operands whose cross products fill the middle columns with ones. If the carry-save alignment were off by one column, or the adder were too narrow, those cases would give a top half that is too small by a power of two. It also drives all-ones operands, which stress every carry path at once and catch a dropped carry bit. It drives pairs that share lower halves but differ in upper halves, which show whether the bypassed low bits leak in terms from the wrong partial product. Zero operands, reset with live inputs, and an input change in the middle of a cycle test the zero result, the cleared register, and the single-cycle latency.

// File: rtl/cm_pkg.sv
package cm_pkg;
  // partial product slots: bit0 picks a half, bit1 picks b half
  typedef enum logic [1:0] {
    PP_LL = 2'd0,
    PP_HL = 2'd1,
    PP_LH = 2'd2,
    PP_HH = 2'd3
  } pp_idx_e;

  localparam int NUM_PP = 4;
endpackage

// File: rtl/cm_sub_mult.sv
module cm_sub_mult #(
  parameter int W = 8
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] p_o
);
  assign p_o = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
endmodule

// File: rtl/cm_csa_row.sv
module cm_csa_row #(
  parameter int W = 24
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);
  // carry_o is pre-shifted to its weight; carry out of the msb is dropped
  assign carry_o[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum_o[i] = x_i[i] ^ y_i[i] ^ z_i[i];
    if (i < W - 1) begin : g_cy
      assign carry_o[i+1] = (x_i[i] & y_i[i]) | (x_i[i] & z_i[i]) | (y_i[i] & z_i[i]);
    end
  end
endmodule

// File: rtl/cm_cpa.sv
module cm_cpa #(
  parameter int W = 24
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] s_o
);
  assign s_o = a_i + b_i;
endmodule

// File: rtl/composite_mult.sv
module composite_mult
  import cm_pkg::*;
#(
  parameter int HALF_W  = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [2*HALF_W-1:0] a_i,
  input  logic [2*HALF_W-1:0] b_i,
  output logic [4*HALF_W-1:0] product_o
);
  localparam int PP_W   = 2 * HALF_W;
  localparam int MID_W  = 3 * HALF_W;
  localparam int PROD_W = 4 * HALF_W;

  logic [1:0][HALF_W-1:0]      a_half, b_half;
  logic [NUM_PP-1:0][PP_W-1:0] pp;

  assign a_half = a_i;
  assign b_half = b_i;

  for (genvar g = 0; g < NUM_PP; g++) begin : g_pp
    localparam int AI = g % 2;
    localparam int BI = g / 2;
    cm_sub_mult #(.W(HALF_W)) u_mul (
      .a_i (a_half[AI]),
      .b_i (b_half[BI]),
      .p_o (pp[g])
    );
  end

  // operands of the 3n window, weight 2^n at bit 0
  logic [MID_W-1:0] op_ll_hi, op_hl, op_lh, op_hh;
  assign op_ll_hi = {{PP_W{1'b0}}, pp[PP_LL][PP_W-1:HALF_W]};
  assign op_hl    = {{HALF_W{1'b0}}, pp[PP_HL]};
  assign op_lh    = {{HALF_W{1'b0}}, pp[PP_LH]};
  assign op_hh    = {pp[PP_HH], {HALF_W{1'b0}}};

  logic [MID_W-1:0] s1, c1, s2, c2, mid_sum;

  cm_csa_row #(.W(MID_W)) u_csa0 (
    .x_i     (op_ll_hi),
    .y_i     (op_hl),
    .z_i     (op_lh),
    .sum_o   (s1),
    .carry_o (c1)
  );

  cm_csa_row #(.W(MID_W)) u_csa1 (
    .x_i     (s1),
    .y_i     (c1),
    .z_i     (op_hh),
    .sum_o   (s2),
    .carry_o (c2)
  );

  cm_cpa #(.W(MID_W)) u_cpa (
    .a_i (s2),
    .b_i (c2),
    .s_o (mid_sum)
  );

  logic [PROD_W-1:0] prod_next;
  assign prod_next = {mid_sum, pp[PP_LL][HALF_W-1:0]};

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) product_o <= '0;
      else         product_o <= prod_next;
    end
  end else begin : g_comb
    assign product_o = prod_next;
  end
endmodule

// File: rtl/composite_mult_chk.sv
module composite_mult_chk #(
  parameter int HALF_W  = 8,
  parameter bit OUT_REG = 1'b1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [2*HALF_W-1:0] a_i,
  input logic [2*HALF_W-1:0] b_i,
  input logic [4*HALF_W-1:0] product_o
);
  localparam int PROD_W = 4 * HALF_W;

  logic [PROD_W-1:0] a_ext, b_ext, lo_ext;
  assign a_ext  = PROD_W'(a_i);
  assign b_ext  = PROD_W'(b_i);
  assign lo_ext = PROD_W'(a_i[HALF_W-1:0]) * PROD_W'(b_i[HALF_W-1:0]);

  if (OUT_REG) begin : g_reg
    assert_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> product_o == $past(a_ext) * $past(b_ext));

    assert_low_bits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> product_o[HALF_W-1:0] == $past(lo_ext[HALF_W-1:0]));

    assert_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && ($past(a_i) == '0 || $past(b_i) == '0)) |-> product_o == '0);

    assert_reset_R3: assert property (@(posedge clk_i)
      !rst_ni |-> product_o == '0);
  end else begin : g_comb
    assert_product_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      product_o == a_ext * b_ext);

    assert_low_bits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      product_o[HALF_W-1:0] == lo_ext[HALF_W-1:0]);

    assert_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_i == '0 || b_i == '0) |-> product_o == '0);

    assert_max_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (&a_i && &b_i) |-> product_o[0] && !product_o[2*HALF_W]);
  end
endmodule

bind composite_mult composite_mult_chk #(.HALF_W(HALF_W), .OUT_REG(OUT_REG)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .a_i       (a_i),
  .b_i       (b_i),
  .product_o (product_o)
);

// File: tb/sim_composite_mult.sv
module sim_composite_mult;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int HW = 8;
  localparam int OW = 2 * HW;
  localparam int PW = 4 * HW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [OW-1:0] a = '0;
  logic [OW-1:0] b = '0;
  logic [PW-1:0] prod;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [PW-1:0] exp;
    string         tag;
  } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  composite_mult #(.HALF_W(HW), .OUT_REG(1'b1)) u0 (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .a_i       (a),
    .b_i       (b),
    .product_o (prod)
  );

  task automatic check(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: apply operands and queue the expected product
  task automatic drive(input string tag, input logic [OW-1:0] x, input logic [OW-1:0] y);
    item_t it;
    @(negedge clk);
    a = x;
    b = y;
    it.exp = PW'(x) * PW'(y);
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor: registered output is valid just after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(it.tag, prod, it.exp);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=hang expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R3: reset with live operands
    a = 16'hBEEF;
    b = 16'h1234;
    repeat (3) @(posedge clk);
    #1;
    check("R3", prod, '0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R6: zero operands
    drive("R6", 16'h0000, 16'hA5C3);
    drive("R6", 16'h7F01, 16'h0000);
    drive("R6", 16'h0000, 16'h0000);

    // R5: all ones on both sides
    drive("R5", 16'hFFFF, 16'hFFFF);
    drive("R1", 16'hFFFF, 16'h0001);

    // R7: middle columns saturated, carries climb into the top
    drive("R7", 16'h01FF, 16'hFF01);
    drive("R7", 16'hFFFF, 16'h00FF);
    drive("R7", 16'h00FF, 16'hFFFF);
    drive("R7", 16'hFF00, 16'h00FF);

    // R4: same low halves, different high halves
    drive("R4", 16'hAB34, 16'hCD56);
    drive("R4", 16'h1234, 16'h9956);
    drive("R4", 16'h0034, 16'hFF56);

    // R1: random operands
    for (int i = 0; i < 200; i++) begin
      drive("R1", OW'($urandom), OW'($urandom));
    end

    // drain the scoreboard
    repeat (3) @(posedge clk);

    // R2: input change between edges leaves output alone until the next edge
    begin
      logic [PW-1:0] prev;
      #1;
      prev = prod;
      @(negedge clk);
      a = 16'd3;
      b = 16'd5;
      #1;
      check("R2", prod, prev);
      @(posedge clk);
      #1;
      check("R2", prod, 32'd15);
    end

    // R3: reset clears a nonzero product
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check("R3", prod, '0);
    @(negedge clk);
    rst_ni = 1'b1;

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule